// File: doc/BRIEF.md
# Audio DSP Command Port

This block is the host-facing side of an audio signal processor. It sits on a byte-wide I/O bus and decodes a small group of port offsets. One port is a reset port with a two-step software reset handshake. One port takes command opcodes followed by their parameter bytes. One port returns response bytes, and two status ports report whether a write may proceed and whether response data is waiting. Reading one of the status ports, or a separate acknowledge port, also clears a pending interrupt.

Each opcode needs a fixed number of parameter bytes, from zero to three. The block collects these bytes and runs the command when the last one arrives. Responses go onto a last-in first-out stack, so the byte pushed last is read first. Sample playback is outside this block. A command that starts a transfer only raises a one-cycle start strobe, with the opcode, the mode byte and the transfer count decoded from its parameters.

Top module: `sdsp_cmd_port`

## Requirements
- R1: After hardware reset the response stack is empty. Offset 0x6 reads 0xFF, offset 0xE reads 0x00 and offset 0xC reads 0x00. Reading offset 0xA returns 0x00, and `irq` is low.
- R2: Writing 0x01 or 0x03 to offset 0x6 arms a software reset, and a following write of 0x00 to offset 0x6 performs it. Any other byte written to offset 0x6 disarms it, and 0x00 with no armed reset has no effect. A software reset empties the response stack and then pushes 0xAA. It also drops any parameter collection in progress and clears both interrupt flags.
- R3: Writing 0xB8 or 0x39 to offset 0x6 performs a software reset at once. Afterwards only 0xAA is left to read.
- R4: A byte written to offset 0xC is an opcode when no parameters are pending, and a parameter byte otherwise. 0xB0..0xCF take 3 parameters. 0x41, 0x48, 0x80 and 0x14 take 2. 0x40, 0xE0 and 0xE4 take 1. 0xE1, 0xE8, 0xF2 and 0xF3 take none.
- R5: Opcode 0xE1 pushes the minor version (5) and then the major version (4). Reads at offset 0xA therefore return 4 and then 5.
- R6: Opcode 0xE0 with parameter p empties the response stack and then pushes the bitwise inverse of p.
- R7: Opcode 0xE4 with parameter p loads an 8-bit test register. Opcode 0xE8 pushes that register's value.
- R8: A read at offset 0xA pops the most recently pushed byte. Bytes pushed while the stack holds RESP_DEPTH entries are dropped. Reading an empty stack returns the last byte popped, or 0x00 if none has been popped since hardware reset.
- R9: Offset 0xC always reads 0x00. Offset 0xE reads 0x80 when the stack is not empty and 0x00 when it is.
- R10: Opcode 0xF2 pushes 0xAA and sets `irq_flags[0]`. Opcode 0xF3 pushes 0xAA and sets `irq_flags[1]`. `irq` is high while either flag is set. A read at offset 0xE clears only flag 0, and a read at offset 0xF clears only flag 1.
- R11: When the third parameter of an opcode in 0xB0..0xCF with bit 3 clear arrives, `dma_go` pulses for one cycle. With it come `dma_op`=opcode, `dma_mode`=parameter 1 and `dma_count`=parameter 2 + 256*parameter 3. The same opcodes with bit 3 set give no pulse. Opcode 0x14 pulses with `dma_mode`=0 and `dma_count`=parameter 1 + 256*parameter 2.
- R12: An opcode not listed in R4 is ignored, and the next byte written to offset 0xC is again taken as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; a read has its side effects at the clock edge |
| bus_addr | input | 4 | Port offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the offset on `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| irq_flags | output | 2 | Pending flags: bit 0 is the 8-bit flag, bit 1 the 16-bit flag |
| dma_go | output | 1 | One-cycle transfer start strobe |
| dma_op | output | 8 | Opcode that started the transfer |
| dma_mode | output | 8 | Mode byte of the transfer |
| dma_count | output | 16 | Transfer count field |

## Verification
The bench builds the block with RESP_DEPTH set to 4, and leaves the parameter buffer depth and the version bytes at their defaults. The shallow stack fills after two version queries. One more push then hits the drop-when-full rule, and reading past the bottom exercises the return of the last popped byte. A deep stack would need dozens of pushes to reach these cases.

// File: rtl/sdsp_pkg.sv
package sdsp_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] PORT_RESET = 4'h6;
  localparam logic [ADDR_W-1:0] PORT_RDATA = 4'hA;
  localparam logic [ADDR_W-1:0] PORT_CMD   = 4'hC;
  localparam logic [ADDR_W-1:0] PORT_RSTAT = 4'hE;
  localparam logic [ADDR_W-1:0] PORT_ACK16 = 4'hF;
  localparam logic [7:0] ACK_BYTE = 8'hAA;

  typedef struct packed {
    logic       known;
    logic [1:0] nparam;
  } op_info_t;

  // Parameter count of each opcode in the supported set
  function automatic op_info_t op_lookup(input logic [7:0] op);
    op_info_t r;
    r.known  = 1'b1;
    r.nparam = 2'd0;
    if (op >= 8'hB0 && op <= 8'hCF) r.nparam = 2'd3;
    else begin
      case (op)
        8'h40, 8'hE0, 8'hE4:        r.nparam = 2'd1;
        8'h41, 8'h48, 8'h80, 8'h14: r.nparam = 2'd2;
        8'hE1, 8'hE8, 8'hF2, 8'hF3: r.nparam = 2'd0;
        default:                    r.known  = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic logic starts_transfer(input logic [7:0] op);
    return (op == 8'h14) || (op >= 8'hB0 && op <= 8'hCF && !op[3]);
  endfunction

  function automatic logic [15:0] xfer_count(input logic [7:0] op, input logic [7:0] p0,
                                             input logic [7:0] p1, input logic [7:0] p2);
    return (op == 8'h14) ? {p1, p0} : {p2, p1};
  endfunction

  function automatic logic [7:0] xfer_mode(input logic [7:0] op, input logic [7:0] p0);
    return (op == 8'h14) ? 8'h00 : p0;
  endfunction
endpackage

// File: rtl/sdsp_reset_seq.sv
module sdsp_reset_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  output logic       fire
);
  logic armed_q;

  always_comb
    fire = wr_en && ((wr_byte == 8'h00 && armed_q) || wr_byte == 8'hB8 || wr_byte == 8'h39);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     armed_q <= 1'b0;
    else if (wr_en) armed_q <= (wr_byte == 8'h01) || (wr_byte == 8'h03);
endmodule

// File: rtl/sdsp_param_collect.sv
module sdsp_param_collect import sdsp_pkg::*; #(
  parameter int DEPTH = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            wr_en,
  input  logic [7:0]      wr_byte,
  output logic            imm_fire,
  output logic            done_fire,
  output logic [7:0]      cur_op,
  output logic [2:0][7:0] par,
  output logic            busy
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][7:0] buf_q;
  logic [CW-1:0]         fill_q;
  logic [1:0]            need_q;
  logic [7:0]            op_q;
  op_info_t              info;

  always_comb begin
    info      = op_lookup(wr_byte);
    busy      = (need_q != 2'd0);
    imm_fire  = wr_en && !busy && info.known && (info.nparam == 2'd0);
    done_fire = wr_en && busy && ((fill_q + CW'(1)) == CW'(need_q));
    cur_op    = busy ? op_q : wr_byte;
  end

  // The byte arriving this cycle stands in for its not-yet-stored slot
  for (genvar i = 0; i < 3; i++) begin : g_par
    assign par[i] = (fill_q == CW'(i)) ? wr_byte : buf_q[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      need_q <= 2'd0;
      fill_q <= '0;
      op_q   <= 8'h00;
    end else if (flush) begin
      need_q <= 2'd0;
      fill_q <= '0;
    end else if (wr_en) begin
      if (!busy) begin
        if (info.known && info.nparam != 2'd0) begin
          need_q <= info.nparam;
          op_q   <= wr_byte;
          fill_q <= '0;
        end
      end else begin
        fill_q <= fill_q + CW'(1);
        if (done_fire) need_q <= 2'd0;
      end
    end

  always_ff @(posedge clk)
    if (wr_en && busy && fill_q < CW'(DEPTH)) buf_q[fill_q] <= wr_byte;
endmodule

// File: rtl/sdsp_resp_lifo.sv
module sdsp_resp_lifo #(
  parameter int DEPTH = 50
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic [1:0]                   push_n,
  input  logic [7:0]                   push_a,
  input  logic [7:0]                   push_b,
  input  logic                         pop,
  output logic [7:0]                   top,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int SLOTS = 1 << CW;

  logic [7:0]    mem [SLOTS];
  logic [CW-1:0] cnt_q, base, after_a, nxt;
  logic          wr_a, wr_b;

  always_comb begin
    base = clr ? '0 : cnt_q;
    if (!clr && pop && cnt_q != '0) base = cnt_q - CW'(1);
    wr_a    = (push_n != 2'd0) && (base < CW'(DEPTH));
    after_a = wr_a ? base + CW'(1) : base;
    wr_b    = (push_n == 2'd2) && (after_a < CW'(DEPTH));
    nxt     = wr_b ? after_a + CW'(1) : after_a;
    top     = (cnt_q == '0) ? 8'h00 : mem[cnt_q - CW'(1)];
    level   = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt;

  always_ff @(posedge clk) begin
    if (wr_a) mem[base]    <= push_a;
    if (wr_b) mem[after_a] <= push_b;
  end
endmodule

// File: rtl/sdsp_cmd_port.sv
module sdsp_cmd_port import sdsp_pkg::*; #(
  parameter int         RESP_DEPTH  = 50,
  parameter int         PARAM_DEPTH = 10,
  parameter logic [7:0] VER_MAJOR   = 8'd4,
  parameter logic [7:0] VER_MINOR   = 8'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic [1:0]        irq_flags,
  output logic              dma_go,
  output logic [7:0]        dma_op,
  output logic [7:0]        dma_mode,
  output logic [15:0]       dma_count
);
  localparam int LW = $clog2(RESP_DEPTH + 1);

  // Named events, also observed by the bound checker
  logic rst_wr, cmd_wr, data_rd, ack8_rd, ack16_rd, soft_rst;
  logic imm_fire, done_fire, prm_busy;
  logic [7:0] cur_op, test_q, last_q, q_top, q_a, q_b;
  logic [2:0][7:0] par;
  logic [LW-1:0] resp_level;
  logic q_clr;
  logic [1:0] q_n;

  always_comb begin
    rst_wr   = bus_wr && bus_addr == PORT_RESET;
    cmd_wr   = bus_wr && bus_addr == PORT_CMD;
    data_rd  = bus_rd && bus_addr == PORT_RDATA;
    ack8_rd  = bus_rd && bus_addr == PORT_RSTAT;
    ack16_rd = bus_rd && bus_addr == PORT_ACK16;
  end

  sdsp_reset_seq u_rst (.clk(clk), .rst_n(rst_n), .wr_en(rst_wr), .wr_byte(bus_wdata),
                        .fire(soft_rst));

  sdsp_param_collect #(.DEPTH(PARAM_DEPTH)) u_prm (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst), .wr_en(cmd_wr), .wr_byte(bus_wdata),
    .imm_fire(imm_fire), .done_fire(done_fire), .cur_op(cur_op), .par(par), .busy(prm_busy));

  always_comb begin
    q_clr = 1'b0; q_n = 2'd0; q_a = 8'h00; q_b = 8'h00;
    if (soft_rst) begin
      q_clr = 1'b1; q_n = 2'd1; q_a = ACK_BYTE;
    end else if (imm_fire) begin
      case (cur_op)
        8'hE1:        begin q_n = 2'd2; q_a = VER_MINOR; q_b = VER_MAJOR; end
        8'hE8:        begin q_n = 2'd1; q_a = test_q; end
        8'hF2, 8'hF3: begin q_n = 2'd1; q_a = ACK_BYTE; end
        default: ;
      endcase
    end else if (done_fire && cur_op == 8'hE0) begin
      q_clr = 1'b1; q_n = 2'd1; q_a = ~par[0];
    end
  end

  sdsp_resp_lifo #(.DEPTH(RESP_DEPTH)) u_resp (
    .clk(clk), .rst_n(rst_n), .clr(q_clr), .push_n(q_n), .push_a(q_a), .push_b(q_b),
    .pop(data_rd), .top(q_top), .level(resp_level));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_flags <= 2'b00; test_q <= 8'h00; last_q <= 8'h00;
      dma_go <= 1'b0; dma_op <= 8'h00; dma_mode <= 8'h00; dma_count <= 16'h0000;
    end else begin
      dma_go <= 1'b0;
      if (data_rd && resp_level != '0) last_q <= q_top;
      if (soft_rst) irq_flags <= 2'b00;
      else begin
        if (ack8_rd)  irq_flags[0] <= 1'b0;
        if (ack16_rd) irq_flags[1] <= 1'b0;
        if (imm_fire && cur_op == 8'hF2) irq_flags[0] <= 1'b1;
        if (imm_fire && cur_op == 8'hF3) irq_flags[1] <= 1'b1;
      end
      if (done_fire && cur_op == 8'hE4) test_q <= par[0];
      if (done_fire && starts_transfer(cur_op)) begin
        dma_go    <= 1'b1;
        dma_op    <= cur_op;
        dma_mode  <= xfer_mode(cur_op, par[0]);
        dma_count <= xfer_count(cur_op, par[0], par[1], par[2]);
      end
    end

  assign irq = |irq_flags;

  always_comb
    case (bus_addr)
      PORT_RDATA: bus_rdata = (resp_level != '0) ? q_top : last_q;
      PORT_CMD:   bus_rdata = 8'h00;
      PORT_RSTAT: bus_rdata = {resp_level != '0, 7'b0};
      default:    bus_rdata = 8'hFF;
    endcase
endmodule

// File: rtl/sdsp_cmd_port_chk.sv
module sdsp_cmd_port_chk import sdsp_pkg::*; #(
  parameter int RESP_DEPTH = 50,
  parameter int LW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic [1:0]        irq_flags,
  input logic              dma_go,
  input logic              soft_rst,
  input logic [LW-1:0]     resp_level
);
  assert_softrst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (resp_level == LW'(1) && irq_flags == 2'b00));

  assert_capacity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_level <= LW'(RESP_DEPTH));

  assert_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == PORT_RDATA && resp_level != '0)
      |=> resp_level == $past(resp_level) - LW'(1));

  assert_status_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == PORT_RSTAT) |-> (bus_rdata[6:0] == 7'd0));

  assert_flag_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flags[0]) |-> $past(bus_wr && bus_addr == PORT_CMD));

  assert_dma_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_go |-> $past(bus_wr && bus_addr == PORT_CMD));

  assert_dma_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_go |=> !dma_go);
endmodule

bind sdsp_cmd_port sdsp_cmd_port_chk #(.RESP_DEPTH(RESP_DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_flags(irq_flags), .dma_go(dma_go), .soft_rst(soft_rst),
  .resp_level(resp_level));

// File: tb/sdsp_cmd_port_bench.sv
module sdsp_cmd_port_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata, dma_op, dma_mode;
  logic irq, dma_go;
  logic [1:0] irq_flags;
  logic [15:0] dma_count;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdsp_cmd_port #(.RESP_DEPTH(4)) u_sdsp_cmd_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .irq_flags(irq_flags),
    .dma_go(dma_go), .dma_op(dma_op), .dma_mode(dma_mode), .dma_count(dma_count));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic expect_rd(input string tag, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    chk(tag, {24'h0, v}, {24'h0, e});
  endtask

  task automatic clean();
    wr(4'h6, 8'hB8);
    expect_rd("R3 clean ack", 4'hA, 8'hAA);
  endtask

  task automatic t_reset_state();
    expect_rd("R1 reset port", 4'h6, 8'hFF);
    expect_rd("R1 read status", 4'hE, 8'h00);
    expect_rd("R1 write status", 4'hC, 8'h00);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    expect_rd("R1 R8 empty read", 4'hA, 8'h00);
  endtask

  task automatic t_version();
    clean();
    wr(4'hC, 8'hE1);
    expect_rd("R9 data avail", 4'hE, 8'h80);
    expect_rd("R5 major", 4'hA, 8'h04);
    expect_rd("R5 minor", 4'hA, 8'h05);
    expect_rd("R9 empty", 4'hE, 8'h00);
  endtask

  task automatic t_handshake();
    clean();
    wr(4'h6, 8'h01); wr(4'h6, 8'h00);
    expect_rd("R2 armed reset ack", 4'hA, 8'hAA);
    expect_rd("R2 only ack", 4'hE, 8'h00);
    wr(4'hC, 8'hE1);
    wr(4'h6, 8'h00);
    expect_rd("R2 unarmed zero ignored", 4'hA, 8'h04);
    expect_rd("R2 unarmed keep", 4'hA, 8'h05);
    wr(4'h6, 8'h03); wr(4'h6, 8'h55); wr(4'h6, 8'h00);
    expect_rd("R2 disarmed", 4'hE, 8'h00);
    wr(4'hC, 8'hE4);
    wr(4'h6, 8'h03); wr(4'h6, 8'h00);
    expect_rd("R2 reset via 03", 4'hA, 8'hAA);
    wr(4'hC, 8'hE1);
    expect_rd("R2 params dropped", 4'hA, 8'h04);
  endtask

  task automatic t_immediate();
    clean();
    wr(4'hC, 8'hE1);
    wr(4'h6, 8'h39);
    expect_rd("R3 0x39 ack", 4'hA, 8'hAA);
    expect_rd("R3 0x39 nothing else", 4'hE, 8'h00);
    wr(4'hC, 8'hE1);
    wr(4'h6, 8'hB8);
    expect_rd("R3 0xB8 ack", 4'hA, 8'hAA);
    expect_rd("R3 0xB8 nothing else", 4'hE, 8'h00);
  endtask

  task automatic t_testreg();
    clean();
    wr(4'hC, 8'hE4); wr(4'hC, 8'h5A);
    expect_rd("R7 no response on load", 4'hE, 8'h00);
    wr(4'hC, 8'hE8);
    expect_rd("R7 test reg", 4'hA, 8'h5A);
  endtask

  task automatic t_invert();
    clean();
    wr(4'hC, 8'hE1);
    wr(4'hC, 8'hE0); wr(4'hC, 8'h3C);
    expect_rd("R6 inverse", 4'hA, 8'hC3);
    expect_rd("R6 discarded", 4'hE, 8'h00);
  endtask

  task automatic t_params();
    clean();
    wr(4'hC, 8'h41); wr(4'hC, 8'hE1); wr(4'hC, 8'hE8);
    expect_rd("R4 0x41 two params", 4'hE, 8'h00);
    wr(4'hC, 8'h40); wr(4'hC, 8'hE1);
    expect_rd("R4 0x40 one param", 4'hE, 8'h00);
    wr(4'hC, 8'h48); wr(4'hC, 8'hE1); wr(4'hC, 8'hE1);
    wr(4'hC, 8'h80); wr(4'hC, 8'hE1); wr(4'hC, 8'hE1);
    expect_rd("R4 0x48 0x80 two params", 4'hE, 8'h00);
    wr(4'hC, 8'hE1);
    expect_rd("R4 back to opcode", 4'hA, 8'h04);
  endtask

  task automatic t_unknown();
    clean();
    wr(4'hC, 8'h37);
    wr(4'hC, 8'hE1);
    expect_rd("R12 unknown ignored", 4'hA, 8'h04);
  endtask

  task automatic t_lifo();
    clean();
    wr(4'hC, 8'hE4); wr(4'hC, 8'h77);
    wr(4'hC, 8'hE1); wr(4'hC, 8'hE1); wr(4'hC, 8'hE8);
    expect_rd("R8 pop 1", 4'hA, 8'h04);
    expect_rd("R8 pop 2", 4'hA, 8'h05);
    expect_rd("R8 pop 3", 4'hA, 8'h04);
    expect_rd("R8 pop 4 overflow dropped", 4'hA, 8'h05);
    expect_rd("R8 empty", 4'hE, 8'h00);
    expect_rd("R8 empty returns last", 4'hA, 8'h05);
  endtask

  task automatic t_irq();
    clean();
    wr(4'hC, 8'hF2);
    chk("R10 flag8", {30'h0, irq_flags}, 32'h1);
    chk("R10 irq high", {31'h0, irq}, 32'h1);
    expect_rd("R10 F2 ack byte", 4'hA, 8'hAA);
    expect_rd("R10 ack16 port", 4'hF, 8'hFF);
    chk("R10 ack16 leaves flag8", {30'h0, irq_flags}, 32'h1);
    expect_rd("R10 status during ack", 4'hE, 8'h00);
    chk("R10 flag8 cleared", {30'h0, irq_flags}, 32'h0);
    chk("R10 irq low", {31'h0, irq}, 32'h0);
    wr(4'hC, 8'hF3);
    chk("R10 flag16", {30'h0, irq_flags}, 32'h2);
    expect_rd("R10 F3 data avail", 4'hE, 8'h80);
    chk("R10 ack8 leaves flag16", {30'h0, irq_flags}, 32'h2);
    expect_rd("R10 ack16", 4'hF, 8'hFF);
    chk("R10 flag16 cleared", {30'h0, irq_flags}, 32'h0);
    wr(4'hC, 8'hF2); wr(4'hC, 8'hF3);
    wr(4'h6, 8'hB8);
    chk("R2 reset clears flags", {30'h0, irq_flags}, 32'h0);
  endtask

  task automatic t_dma();
    clean();
    wr(4'hC, 8'hB6); wr(4'hC, 8'h30); wr(4'hC, 8'h34);
    chk("R11 no early strobe", {31'h0, dma_go}, 32'h0);
    wr(4'hC, 8'h12);
    chk("R11 strobe", {31'h0, dma_go}, 32'h1);
    chk("R11 op", {24'h0, dma_op}, 32'hB6);
    chk("R11 mode", {24'h0, dma_mode}, 32'h30);
    chk("R11 count", {16'h0, dma_count}, 32'h1234);
    @(negedge clk);
    chk("R11 one cycle", {31'h0, dma_go}, 32'h0);
    wr(4'hC, 8'hC8); wr(4'hC, 8'h00); wr(4'hC, 8'h01);
    wr(4'hC, 8'h02);
    chk("R11 bit3 no strobe", {31'h0, dma_go}, 32'h0);
    wr(4'hC, 8'h14); wr(4'hC, 8'h78);
    wr(4'hC, 8'h56);
    chk("R11 0x14 strobe", {31'h0, dma_go}, 32'h1);
    chk("R11 0x14 op", {24'h0, dma_op}, 32'h14);
    chk("R11 0x14 mode", {24'h0, dma_mode}, 32'h00);
    chk("R11 0x14 count", {16'h0, dma_count}, 32'h5678);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired got=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_version();
    t_handshake();
    t_immediate();
    t_testreg();
    t_invert();
    t_params();
    t_unknown();
    t_lifo();
    t_irq();
    t_dma();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule